// File: doc/BRIEF.md
# In-System Flash Programming Controller

This block lets firmware modify an on-chip nonvolatile program store without an external programmer. The store is modelled as an internal byte array. A host writes a small set of byte registers: a key register holding a global enable bit, a high and a low address byte, a data byte and a command register. Setting the start bit of the command register launches one of four operations: byte program, page erase, chip erase or protect. The start bit then reads back as a busy flag that clears itself when the operation is over.

A combinational read port returns store contents. Once the protect command has run, every read returns zero until a chip erase lifts the protection. A reserved region holds resident service code. It comes out of reset filled with a fixed pattern, and no operation ever alters it.

Top module: `isp_prog_unit`

## Requirements
- R1: After reset `busy` is low, the store is unprotected, locations outside the reserved region read 0xFF and reserved locations read `RSV_FILL`.
- R2: A command write with bit 7 set is ignored unless bit 2 of the key register (select 0) is 1; `busy` stays low and the store is unchanged.
- R3: Select 1 holds the high address byte, select 2 the low byte and select 3 the data byte. Byte program (code 0) stores old value AND data at the 16-bit address.
- R4: Select 4 is the command register. Bit 7 starts an operation and bits [2:0] hold the code. `busy` rises in the cycle after an accepted start. Codes 4 to 7 keep `busy` high for one cycle and change nothing.
- R5: Byte program keeps `busy` high for exactly `PROG_LAT` cycles, whether or not the write is rejected.
- R6: Page erase (code 1) sets the 512 bytes whose high address byte shares bits [7:1] with the high register to 0xFF. An even high byte covers itself and the next byte; an odd one covers the previous byte and itself. Other bytes are untouched, and `busy` lasts 512 cycles.
- R7: Chip erase (code 2) sets every non-reserved location to 0xFF, takes one cycle per store byte (2048 by default), and leaves the reserved region intact.
- R8: Chip erase removes protection, in the same cycle that `busy` falls.
- R9: After protect (code 3, one busy cycle), every read returns 0x00.
- R10: Byte program to a reserved address, and page erase of a page overlapping the reserved region, write nothing. A page erase rejected this way lasts one cycle.
- R11: Register writes of any select made while `busy` is high are ignored, including one in the final busy cycle.
- R12: A target address with bits at or above `STORE_AW` set is out of range. Byte program and page erase to it write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 3 | Register select (0 key, 1 addr high, 2 addr low, 3 data, 4 command) |
| wrData | input | 8 | Register write data |
| rdAddr | input | STORE_AW | Store read address |
| rdData | output | 8 | Store read data, zero when protected |
| busy | output | 1 | Start bit; high while an operation runs |

## Verification
Two events can fall in the same cycle here. The first is a host register write arriving in the last cycle of an operation, on the same edge where the start bit clears. The bench drives a new start command exactly in the final busy cycle of a byte program. It judges the command ignored if `busy` is low at the next sample. The second is the chip erase's final store write coinciding with the protection release; a checker property ties the fall of protection to the fall of `busy`, and the bench reads erased bytes straight after completion.

// File: rtl/isp_pkg.sv
package isp_pkg;
  localparam logic [2:0] SEL_KEY  = 3'd0;
  localparam logic [2:0] SEL_AHI  = 3'd1;
  localparam logic [2:0] SEL_ALO  = 3'd2;
  localparam logic [2:0] SEL_DATA = 3'd3;
  localparam logic [2:0] SEL_CMD  = 3'd4;

  localparam logic [2:0] OP_PROG = 3'd0;
  localparam logic [2:0] OP_PAGE = 3'd1;
  localparam logic [2:0] OP_CHIP = 3'd2;
  localparam logic [2:0] OP_LOCK = 3'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_PROG, ST_WALK, ST_FIN} stateT;

  typedef struct packed {
    logic wr;       // write one store byte this cycle
    logic andMode;  // 1: old AND value, 0: erase to 0xFF
    logic setLock;
    logic clrLock;
  } strobeT;
endpackage

// File: rtl/isp_ctrl.sv
module isp_ctrl
  import isp_pkg::*;
#(
  parameter int unsigned STORE_AW = 11,
  parameter int unsigned PAGE_AW  = 9,
  parameter int unsigned PROG_LAT = 4,
  parameter int unsigned RSV_BASE = 32'h700,
  parameter int unsigned RSV_LAST = 32'h7FF
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [2:0]          wrSel,
  input  logic [7:0]          wrData,
  output logic                busy,
  output logic                ispEn,
  output strobeT              strb,
  output logic [STORE_AW-1:0] wrIdx,
  output logic [7:0]          wrVal
);
  localparam int unsigned CNT_W = $clog2(PROG_LAT + 1);
  localparam logic [STORE_AW-1:0] RSV_LO = STORE_AW'(RSV_BASE);
  localparam logic [STORE_AW-1:0] RSV_HI = STORE_AW'(RSV_LAST);
  localparam logic [CNT_W-1:0]    CNT_END = CNT_W'(PROG_LAT - 1);

  stateT               state;
  logic [7:0]          addrHi, addrLo, dataReg;
  logic [2:0]          opCode;
  logic [CNT_W-1:0]    cnt;
  logic [STORE_AW-1:0] cur, last;
  logic                start;

  logic [15:0]         fullAddr;
  logic                outOfRange;
  logic [STORE_AW-1:0] tgt, pageLo, pageHi;
  logic                pageBad, take;

  function automatic logic inRsv(input logic [STORE_AW-1:0] a);
    return (a >= RSV_LO) && (a <= RSV_HI);
  endfunction

  always_comb begin
    fullAddr   = {addrHi, addrLo};
    outOfRange = (fullAddr >> STORE_AW) != 16'd0;
    tgt        = fullAddr[STORE_AW-1:0];
    pageLo     = tgt & ~STORE_AW'((1 << PAGE_AW) - 1);
    pageHi     = tgt |  STORE_AW'((1 << PAGE_AW) - 1);
    pageBad    = outOfRange || ((pageLo <= RSV_HI) && (pageHi >= RSV_LO));
    take       = wrEn && !start;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE; start <= 1'b0; ispEn <= 1'b0;
      addrHi <= '0; addrLo <= '0; dataReg <= '0; opCode <= '0;
      cnt <= '0; cur <= '0; last <= '0;
    end else begin
      if (take) begin
        case (wrSel)
          SEL_KEY:  ispEn   <= wrData[2];
          SEL_AHI:  addrHi  <= wrData;
          SEL_ALO:  addrLo  <= wrData;
          SEL_DATA: dataReg <= wrData;
          SEL_CMD: if (wrData[7] && ispEn) begin
            start  <= 1'b1;
            opCode <= wrData[2:0];
            cnt    <= '0;
            case (wrData[2:0])
              OP_PROG: state <= ST_PROG;
              OP_PAGE: if (pageBad) state <= ST_FIN;
                       else begin state <= ST_WALK; cur <= pageLo; last <= pageHi; end
              OP_CHIP: begin state <= ST_WALK; cur <= '0; last <= '1; end
              default: state <= ST_FIN;
            endcase
          end
          default: ;
        endcase
      end
      case (state)
        ST_PROG: if (cnt == CNT_END) begin state <= ST_IDLE; start <= 1'b0; end
                 else cnt <= cnt + 1'b1;
        ST_WALK: if (cur == last) begin state <= ST_IDLE; start <= 1'b0; end
                 else cur <= cur + 1'b1;
        ST_FIN:  begin state <= ST_IDLE; start <= 1'b0; end
        default: ;
      endcase
    end
  end

  always_comb begin
    strb  = '0;
    wrIdx = cur;
    wrVal = 8'hFF;
    case (state)
      ST_PROG: begin
        wrIdx        = tgt;
        wrVal        = dataReg;
        strb.andMode = 1'b1;
        strb.wr      = (cnt == CNT_END) && !outOfRange && !inRsv(tgt);
      end
      ST_WALK: begin
        strb.wr      = !inRsv(cur);
        strb.clrLock = (cur == last) && (opCode == OP_CHIP);
      end
      ST_FIN:  strb.setLock = (opCode == OP_LOCK);
      default: ;
    endcase
  end

  assign busy = start;
endmodule

// File: rtl/isp_store.sv
module isp_store
  import isp_pkg::*;
#(
  parameter int unsigned STORE_AW = 11,
  parameter int unsigned RSV_BASE = 32'h700,
  parameter int unsigned RSV_LAST = 32'h7FF,
  parameter logic [7:0]  RSV_FILL = 8'hA5
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              strb,
  input  logic [STORE_AW-1:0] wrIdx,
  input  logic [7:0]          wrVal,
  input  logic [STORE_AW-1:0] rdAddr,
  output logic [7:0]          rdData,
  output logic                locked
);
  localparam int unsigned DEPTH = 1 << STORE_AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= (i >= int'(RSV_BASE) && i <= int'(RSV_LAST)) ? RSV_FILL : 8'hFF;
      locked <= 1'b0;
    end else begin
      if (strb.wr) mem[wrIdx] <= strb.andMode ? (mem[wrIdx] & wrVal) : 8'hFF;
      if (strb.setLock)      locked <= 1'b1;
      else if (strb.clrLock) locked <= 1'b0;
    end
  end

  assign rdData = locked ? 8'h00 : mem[rdAddr];
endmodule

// File: rtl/isp_prog_unit.sv
module isp_prog_unit
  import isp_pkg::*;
#(
  parameter int unsigned STORE_AW = 11,
  parameter int unsigned PAGE_AW  = 9,
  parameter int unsigned PROG_LAT = 4,
  parameter int unsigned RSV_BASE = 32'h700,
  parameter int unsigned RSV_LAST = 32'h7FF,
  parameter logic [7:0]  RSV_FILL = 8'hA5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [2:0]          wrSel,
  input  logic [7:0]          wrData,
  input  logic [STORE_AW-1:0] rdAddr,
  output logic [7:0]          rdData,
  output logic                busy
);
  strobeT              strb;
  logic [STORE_AW-1:0] wrIdx;
  logic [7:0]          wrVal;
  logic                ispEn, locked;

  isp_ctrl #(.STORE_AW(STORE_AW), .PAGE_AW(PAGE_AW), .PROG_LAT(PROG_LAT),
             .RSV_BASE(RSV_BASE), .RSV_LAST(RSV_LAST)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .busy(busy), .ispEn(ispEn), .strb(strb), .wrIdx(wrIdx), .wrVal(wrVal));

  isp_store #(.STORE_AW(STORE_AW), .RSV_BASE(RSV_BASE), .RSV_LAST(RSV_LAST),
              .RSV_FILL(RSV_FILL)) u_store (
    .clk(clk), .rstN(rstN), .strb(strb), .wrIdx(wrIdx), .wrVal(wrVal),
    .rdAddr(rdAddr), .rdData(rdData), .locked(locked));
endmodule

// File: rtl/isp_prog_chk.sv
module isp_prog_chk #(
  parameter int unsigned STORE_AW = 11,
  parameter int unsigned RSV_BASE = 32'h700,
  parameter int unsigned RSV_LAST = 32'h7FF
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic [2:0]          wrSel,
  input logic [7:0]          wrData,
  input logic                busy,
  input logic                ispEn,
  input logic                locked,
  input logic                strbWr,
  input logic [STORE_AW-1:0] wrIdx
);
  localparam logic [STORE_AW-1:0] RSV_LO = STORE_AW'(RSV_BASE);
  localparam logic [STORE_AW-1:0] RSV_HI = STORE_AW'(RSV_LAST);

  assert_key_gate_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 3'd4 && wrData[7] && !busy && !ispEn) |=> !busy);

  assert_start_source_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wrEn && wrSel == 3'd4 && wrData[7]));

  assert_write_in_op_R4: assert property (@(posedge clk) disable iff (!rstN)
    strbWr |-> busy);

  assert_unlock_at_end_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> $fell(busy));

  assert_lock_at_end_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $fell(busy));

  assert_rsv_spared_R10: assert property (@(posedge clk) disable iff (!rstN)
    strbWr |-> (wrIdx < RSV_LO || wrIdx > RSV_HI));
endmodule

bind isp_prog_unit isp_prog_chk #(.STORE_AW(STORE_AW), .RSV_BASE(RSV_BASE),
                                  .RSV_LAST(RSV_LAST)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
  .busy(busy), .ispEn(ispEn), .locked(locked), .strbWr(strb.wr), .wrIdx(wrIdx));

// File: tb/sim_isp_prog_unit.sv
module sim_isp_prog_unit;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 11;
  localparam int LAT = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [2:0]    wrSel = '0;
  logic [7:0]    wrData = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [7:0]    rdData;
  logic          busy;
  int total = 0, bad = 0;
  bit finished = 0;

  isp_prog_unit u0 (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
                    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .busy(busy));

  always #(CLK_PERIOD/2) clk = ~clk;

  // byte program vectors: addrHi, addrLo, data, expected read at {hi,lo}[10:0]
  localparam logic [31:0] VEC [8] = '{
    32'h01_05_22_22,  // R3 fresh byte
    32'h01_05_F0_20,  // R3 AND with old value
    32'h00_00_5A_5A,  // R3
    32'h06_FF_81_81,  // R3 last byte below reserved
    32'h07_10_00_A5,  // R10 reserved target rejected
    32'h08_00_00_5A,  // R12 out of range; alias 0x000 unchanged
    32'h02_10_0F_0F,  // R3
    32'h04_00_44_44   // R3
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic runCmd(input logic [7:0] cmd, output int cyc);
    wr(3'd4, cmd);
    cyc = 0;
    while (busy && cyc < 5000) begin cyc++; @(negedge clk); end
  endtask

  task automatic rd(input string req, input int a, input int exp);
    rdAddr = AW'(a); #1;
    check(req, int'(rdData), exp);
  endtask

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 busy", int'(busy), 0);
    rd("R1", 'h000, 'hFF); rd("R1", 'h123, 'hFF); rd("R1 fill", 'h710, 'hA5);

    // key clear: start ignored
    wr(3'd1, 8'h01); wr(3'd2, 8'h05); wr(3'd3, 8'h22);
    wr(3'd4, 8'h80);
    check("R2 busy", int'(busy), 0);
    rd("R2", 'h105, 'hFF);

    wr(3'd0, 8'h04);
    for (int i = 0; i < 8; i++) begin
      wr(3'd1, VEC[i][31:24]); wr(3'd2, VEC[i][23:16]); wr(3'd3, VEC[i][15:8]);
      runCmd(8'h80, cyc);
      check("R5 prog cycles", cyc, LAT);
      rd("R3/R10/R12 vec", int'({VEC[i][31:24], VEC[i][23:16]}) & 'h7FF, int'(VEC[i][7:0]));
    end

    // unknown code
    runCmd(8'h85, cyc);
    check("R4 unknown code cycles", cyc, 1);
    rd("R4 unchanged", 'h210, 'h0F);

    // writes while busy are ignored
    wr(3'd1, 8'h03); wr(3'd2, 8'h00); wr(3'd3, 8'h11);
    wr(3'd4, 8'h80);
    wr(3'd2, 8'h01);
    while (busy) @(negedge clk);
    rd("R11 addr kept", 'h300, 'h11);
    rd("R11 no alias", 'h301, 'hFF);

    // command arriving in the final busy cycle
    wr(3'd4, 8'h80);
    repeat (LAT - 1) @(negedge clk);
    wrEn = 1'b1; wrSel = 3'd4; wrData = 8'h80;
    @(negedge clk); wrEn = 1'b0;
    check("R11 last-cycle start", int'(busy), 0);

    // page erase, odd high byte 0x01 -> 0x000..0x1FF
    wr(3'd1, 8'h01);
    runCmd(8'h81, cyc);
    check("R6 page cycles", cyc, 512);
    rd("R6", 'h000, 'hFF); rd("R6", 'h105, 'hFF); rd("R6 outside", 'h210, 'h0F);

    // page overlapping reserved region
    wr(3'd1, 8'h07);
    runCmd(8'h81, cyc);
    check("R10 page reject cycles", cyc, 1);
    rd("R10", 'h6FF, 'h81);

    // even high byte 0x02 -> 0x200..0x3FF
    wr(3'd1, 8'h02);
    runCmd(8'h81, cyc);
    check("R6 even page cycles", cyc, 512);
    rd("R6", 'h210, 'hFF); rd("R6", 'h300, 'hFF); rd("R6 outside", 'h400, 'h44);

    // protect
    runCmd(8'h83, cyc);
    check("R9 cycles", cyc, 1);
    rd("R9", 'h400, 'h00); rd("R9", 'h6FF, 'h00);

    // chip erase
    runCmd(8'h82, cyc);
    check("R7 chip cycles", cyc, 2048);
    rd("R8 R7", 'h400, 'hFF); rd("R7", 'h6FF, 'hFF); rd("R7 reserved", 'h710, 'hA5);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule